// File: doc/BRIEF.md
# Triple-Redundant Self-Scrubbing Register

This block is a register bank of parameterised width in which every bit is stored six times: three redundant copies in a capture (master) stage and three in an output (slave) stage. Each copy's next value in the hold state comes from a majority vote across its three sibling copies. A single disturbed copy is therefore rebuilt on the next hold cycle. There is no need for a data load, and the clock enable does not have to rise. Upsets cannot build up while the register sits idle. The output is the majority of the three slave copies.

The register acts as an enabled D flip-flop. A build-time parameter selects asynchronous active-low clear, asynchronous active-low preset, or no asynchronous initialisation. A fault-injection port lets a bench invert chosen bits of chosen copies in either stage, one cycle at a time. A flag reports when a single injection hit two or more copies of the same bit. A test port reaches each of the three copies on its own: three write selects and three read selects. This port works only while a static test-enable input is high and the build-time test permission is set. While the test port is enabled, the vote is removed from the hold loop, so each copy keeps its own value and can be examined.

Top module: `tmr_scrub_reg`

## Requirements
- R1: When `arst_n` is low, the register is initialised at once, without waiting for a clock edge. With the default clear kind, `q` reads all zeros; with the preset kind it reads all ones. `dbl_fault` reads 0.
- R2: On a rising edge with `en` high, `q` takes `d`. This holds when the test port is off and at most one copy is injected.
- R3: On a rising edge with `en` low, `q` keeps its value. This holds when the test port is off and at most one copy is injected.
- R4: An injection into any one copy of either stage never changes `q`. With the test port off, on the next edge without injection all three copies of each stage agree again.
- R5: `dbl_fault` is 1 in the cycle after an edge where `inj_copies` had two or more bits set and `inj_mask` was non-zero. Otherwise it is 0.
- R6: A slave-stage injection into two copies inverts the masked bits of `q` at that edge. The inverted value then persists, because the scrub converges on the new majority.
- R7: With `test_en` high, setting `tst_wr_sel[k]` writes `tst_wdata` into copy k of both stages at the edge. Bit k selects copy k. The other copies are untouched.
- R8: `tst_rdata` is the OR of the slave copies picked by `tst_rd_sel`, where bit k picks copy k. It reads zero whenever `test_en` is low.
- R9: With `test_en` low, the test write selects have no effect on any copy.
- R10: While `test_en` is high, the vote is out of the hold loop, so a written copy keeps its value. On the first edge after `test_en` falls, every copy takes the majority value.
- R11: A test write overrides a capture for the written copies. The slave stage loads the majority of the master copies' next values, so `q` takes the test data when two or more copies are written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| arst_n | input | 1 | Asynchronous initialise, active low (clear or preset by parameter) |
| en | input | 1 | Capture enable |
| d | input | WIDTH | Data in |
| q | output | WIDTH | Majority of the three slave copies |
| dbl_fault | output | 1 | Multi-copy injection seen on the previous edge |
| inj_copies | input | 3 | Copies to disturb, bit k = copy k |
| inj_slave | input | 1 | 1 = inject into slave stage, 0 = master stage |
| inj_mask | input | WIDTH | Bits to invert in the chosen copies |
| test_en | input | 1 | Static test-access enable |
| tst_wr_sel | input | 3 | Per-copy write selects |
| tst_wdata | input | WIDTH | Test write data |
| tst_rd_sel | input | 3 | Per-copy read selects |
| tst_rdata | output | WIDTH | Selected slave copy data |

## Verification
Two kinds of event can land on the same edge, and the bench provokes both.

The first is an injection arriving together with a capture. A master copy is flipped while `en` loads new data. The bench expects `q` to show the new data cleanly, and expects the copies read through the test port afterwards to agree.

The second is a test write arriving together with a capture. Two copies are written while `en` loads different data. The bench expects the slave stage and `q` to follow the majority, which here is the written value, and expects the unwritten copy's slave to follow as well.

A master double injection taken while `en` is low must raise `dbl_fault` and leave `q` alone until the next capture.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Asynchronous initialisation variant chosen at build time
    typedef enum logic [1:0] {
        RK_NONE   = 2'd0,
        RK_CLEAR  = 2'd1,
        RK_PRESET = 2'd2
    } rst_kind_e;

    localparam int unsigned NCOPY = 3;

endpackage

// File: rtl/tmr_vote.sv
module tmr_vote #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] c_i,
    output logic [W-1:0] y_o
);
    // bitwise two-of-three
    for (genvar b = 0; b < W; b++) begin : g_bit
        assign y_o[b] = (a_i[b] & b_i[b]) | (a_i[b] & c_i[b]) | (b_i[b] & c_i[b]);
    end
endmodule

// File: rtl/tmr_stage.sv
module tmr_stage
    import tmr_pkg::*;
#(
    parameter int unsigned W        = 8,
    parameter rst_kind_e   RST_KIND = RK_CLEAR
) (
    input  logic                     clk,
    input  logic                     arst_n,
    input  logic                     tst_on,
    input  logic                     load,
    input  logic [W-1:0]             load_val,
    input  logic [NCOPY-1:0]         inj_copies,
    input  logic [W-1:0]             inj_mask,
    input  logic [NCOPY-1:0]         tst_wr_sel,
    input  logic [W-1:0]             tst_wdata,
    output logic [NCOPY-1:0][W-1:0]  cp_q_o,
    output logic [NCOPY-1:0][W-1:0]  cp_d_o
);
    localparam logic [W-1:0] INIT_VAL = (RST_KIND == RK_PRESET) ? {W{1'b1}} : {W{1'b0}};

    typedef struct packed {
        logic [NCOPY-1:0][W-1:0] cp;
    } stage_t;

    stage_t st_d, st_q;
    logic [W-1:0] vote_w;

    // Hold-loop voter across the three stored copies
    tmr_vote #(.W(W)) u_hold_vote (
        .a_i (st_q.cp[0]),
        .b_i (st_q.cp[1]),
        .c_i (st_q.cp[2]),
        .y_o (vote_w)
    );

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NCOPY; k++) begin
            logic [W-1:0] nxt;
            // test access removes the vote so each copy keeps its own value
            nxt = tst_on ? st_q.cp[k] : vote_w;
            if (load) nxt = load_val;
            if (inj_copies[k]) nxt = nxt ^ inj_mask;
            if (tst_on && tst_wr_sel[k]) nxt = tst_wdata;
            st_d.cp[k] = nxt;
        end
    end

    if (RST_KIND == RK_NONE) begin : g_plain
        always_ff @(posedge clk) begin
            st_q <= st_d;
        end
    end else begin : g_async
        always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) st_q <= {NCOPY{INIT_VAL}};
            else         st_q <= st_d;
        end
    end

    assign cp_q_o = st_q.cp;
    assign cp_d_o = st_d.cp;

    // R4: with no disturbance and no test access, the copies agree after the edge
    p_scrub_converge_r4: assert property (@(posedge clk) disable iff (!arst_n)
        (!tst_on && inj_copies == '0) |=>
        (cp_q_o[0] == cp_q_o[1] && cp_q_o[1] == cp_q_o[2]));

    // R9: with test access off, written data never appears unless loaded or voted
    p_test_locked_r9: assert property (@(posedge clk) disable iff (!arst_n)
        (!tst_on && !load && inj_copies == '0) |=> (cp_q_o[0] == $past(vote_w)));

endmodule

// File: rtl/tmr_scrub_reg.sv
module tmr_scrub_reg
    import tmr_pkg::*;
#(
    parameter int unsigned WIDTH      = 8,
    parameter rst_kind_e   RST_KIND   = RK_CLEAR,
    parameter bit          TEST_ALLOW = 1'b1
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             en,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q,
    output logic             dbl_fault,
    input  logic [2:0]       inj_copies,
    input  logic             inj_slave,
    input  logic [WIDTH-1:0] inj_mask,
    input  logic             test_en,
    input  logic [2:0]       tst_wr_sel,
    input  logic [WIDTH-1:0] tst_wdata,
    input  logic [2:0]       tst_rd_sel,
    output logic [WIDTH-1:0] tst_rdata
);
    typedef struct packed {
        logic dbl;
    } flag_t;

    logic                         tst_on;
    logic [2:0]                   inj_m, inj_s;
    logic [NCOPY-1:0][WIDTH-1:0]  m_q, m_d, s_q, s_d;
    logic [WIDTH-1:0]             m_vote_d;
    flag_t                        fl_d, fl_q;

    assign tst_on = TEST_ALLOW && test_en;
    assign inj_m  = inj_slave ? 3'b000 : inj_copies;
    assign inj_s  = inj_slave ? inj_copies : 3'b000;

    tmr_stage #(.W(WIDTH), .RST_KIND(RST_KIND)) u_master (
        .clk        (clk),
        .arst_n     (arst_n),
        .tst_on     (tst_on),
        .load       (en),
        .load_val   (d),
        .inj_copies (inj_m),
        .inj_mask   (inj_mask),
        .tst_wr_sel (tst_wr_sel),
        .tst_wdata  (tst_wdata),
        .cp_q_o     (m_q),
        .cp_d_o     (m_d)
    );

    // slave stage loads the vote of the master copies' next values
    tmr_vote #(.W(WIDTH)) u_xfer_vote (
        .a_i (m_d[0]),
        .b_i (m_d[1]),
        .c_i (m_d[2]),
        .y_o (m_vote_d)
    );

    tmr_stage #(.W(WIDTH), .RST_KIND(RST_KIND)) u_slave (
        .clk        (clk),
        .arst_n     (arst_n),
        .tst_on     (tst_on),
        .load       (en),
        .load_val   (m_vote_d),
        .inj_copies (inj_s),
        .inj_mask   (inj_mask),
        .tst_wr_sel (tst_wr_sel),
        .tst_wdata  (tst_wdata),
        .cp_q_o     (s_q),
        .cp_d_o     (s_d)
    );

    tmr_vote #(.W(WIDTH)) u_out_vote (
        .a_i (s_q[0]),
        .b_i (s_q[1]),
        .c_i (s_q[2]),
        .y_o (q)
    );

    always_comb begin
        tst_rdata = '0;
        for (int k = 0; k < NCOPY; k++) begin
            if (tst_on && tst_rd_sel[k]) tst_rdata = tst_rdata | s_q[k];
        end
    end

    always_comb begin
        fl_d.dbl = (|inj_mask) && ($countones(inj_copies) >= 2);
    end

    if (RST_KIND == RK_NONE) begin : g_flag_plain
        always_ff @(posedge clk) begin
            fl_q <= fl_d;
        end
    end else begin : g_flag_async
        always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) fl_q <= '0;
            else         fl_q <= fl_d;
        end
    end

    assign dbl_fault = fl_q.dbl;

    // R2: capture
    p_capture_r2: assert property (@(posedge clk) disable iff (!arst_n)
        (en && !tst_on && $countones(inj_copies) <= 1) |=> (q == $past(d)));

    // R3: hold
    p_hold_r3: assert property (@(posedge clk) disable iff (!arst_n)
        (!en && !tst_on && $countones(inj_copies) <= 1) |=> $stable(q));

    // R5: double-injection flag
    p_dbl_flag_r5: assert property (@(posedge clk) disable iff (!arst_n)
        ((|inj_mask) && $countones(inj_copies) >= 2) |=> dbl_fault);

    // R8: read port silent outside test mode
    p_rd_quiet_r8: assert property (@(posedge clk) disable iff (!arst_n)
        !test_en |-> (tst_rdata == '0));

    // R4: single slave injection keeps output voted
    p_single_inj_r4: assert property (@(posedge clk) disable iff (!arst_n)
        (inj_slave && $countones(inj_copies) == 1 && !en && !tst_on) |=> (q == $past(q)));

endmodule

// File: tb/tmr_scrub_reg_bench.sv
module tmr_scrub_reg_bench;
    import tmr_pkg::*;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         arst_n = 1'b0;
    logic         en = 1'b0;
    logic [W-1:0] d = '0;
    logic [W-1:0] q;
    logic         dbl_fault;
    logic [2:0]   inj_copies = '0;
    logic         inj_slave = 1'b0;
    logic [W-1:0] inj_mask = '0;
    logic         test_en = 1'b0;
    logic [2:0]   tst_wr_sel = '0;
    logic [W-1:0] tst_wdata = '0;
    logic [2:0]   tst_rd_sel = '0;
    logic [W-1:0] tst_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    tmr_scrub_reg #(.WIDTH(W), .RST_KIND(RK_CLEAR), .TEST_ALLOW(1'b1)) u_tmr_scrub_reg (
        .clk        (clk),
        .arst_n     (arst_n),
        .en         (en),
        .d          (d),
        .q          (q),
        .dbl_fault  (dbl_fault),
        .inj_copies (inj_copies),
        .inj_slave  (inj_slave),
        .inj_mask   (inj_mask),
        .test_en    (test_en),
        .tst_wr_sel (tst_wr_sel),
        .tst_wdata  (tst_wdata),
        .tst_rd_sel (tst_rd_sel),
        .tst_rdata  (tst_rdata)
    );

    typedef struct {
        logic [W-1:0] q;
        logic         dbl;
        logic [W-1:0] rd;
        string        tag;
    } exp_t;

    exp_t sb[$];

    task automatic check(input string tag, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    // monitor: compares after each edge that follows a driven step
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, "q", q, e.q);
                check(e.tag, "dbl_fault", {{(W-1){1'b0}}, dbl_fault}, {{(W-1){1'b0}}, e.dbl});
                check(e.tag, "tst_rdata", tst_rdata, e.rd);
            end
        end
    end

    // driver: sets inputs for one edge and queues the expected result
    task automatic step(input logic e_i, input logic [W-1:0] d_i,
                        input logic [2:0] ic, input logic is, input logic [W-1:0] im,
                        input logic te, input logic [2:0] ws, input logic [W-1:0] wd,
                        input logic [2:0] rs,
                        input logic [W-1:0] xq, input logic xdbl, input logic [W-1:0] xrd,
                        input string tag);
        exp_t e;
        @(negedge clk);
        en = e_i; d = d_i; inj_copies = ic; inj_slave = is; inj_mask = im;
        test_en = te; tst_wr_sel = ws; tst_wdata = wd; tst_rd_sel = rs;
        e.q = xq; e.dbl = xdbl; e.rd = xrd; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle_step(input logic [W-1:0] xq, input string tag);
        step(1'b0, '0, 3'b000, 1'b0, '0, 1'b0, 3'b000, '0, 3'b000, xq, 1'b0, '0, tag);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        #0;
        check("R1", "q in reset", q, 8'h00);
        check("R1", "dbl in reset", {7'd0, dbl_fault}, 8'h00);
        arst_n = 1'b1;

        // R2 / R3 capture and hold
        step(1, 8'hA5, 3'b000, 0, 8'h00, 0, 3'b000, 8'h00, 3'b000, 8'hA5, 0, 8'h00, "R2");
        step(0, 8'h3C, 3'b000, 0, 8'h00, 0, 3'b000, 8'h00, 3'b000, 8'hA5, 0, 8'h00, "R3");
        step(1, 8'h3C, 3'b000, 0, 8'h00, 0, 3'b000, 8'h00, 3'b000, 8'h3C, 0, 8'h00, "R2");

        // R4 single slave injection, then scrub
        step(0, 8'h00, 3'b010, 1, 8'hFF, 0, 3'b000, 8'h00, 3'b000, 8'h3C, 0, 8'h00, "R4");
        idle_step(8'h3C, "R4");
        // R4 master injection coinciding with a capture
        step(1, 8'h77, 3'b100, 0, 8'h0F, 0, 3'b000, 8'h00, 3'b000, 8'h77, 0, 8'h00, "R4");
        idle_step(8'h77, "R4");
        for (int k = 0; k < 3; k++) begin
            step(0, 8'h00, 3'b000, 0, 8'h00, 1, 3'b000, 8'h00, 3'(1 << k), 8'h77, 0, 8'h77, "R4_R8");
        end

        // R9 / R8: writes ignored and read silent with test off
        step(0, 8'h00, 3'b000, 0, 8'h00, 0, 3'b001, 8'h00, 3'b001, 8'h77, 0, 8'h00, "R9_R8");
        step(0, 8'h00, 3'b000, 0, 8'h00, 1, 3'b000, 8'h00, 3'b001, 8'h77, 0, 8'h77, "R9");

        // R7 single copy write, others untouched, held while test on
        step(0, 8'h00, 3'b000, 0, 8'h00, 1, 3'b001, 8'hE1, 3'b001, 8'h77, 0, 8'hE1, "R7");
        step(0, 8'h00, 3'b000, 0, 8'h00, 1, 3'b000, 8'h00, 3'b010, 8'h77, 0, 8'h77, "R7");
        step(0, 8'h00, 3'b000, 0, 8'h00, 1, 3'b000, 8'h00, 3'b001, 8'h77, 0, 8'hE1, "R10");

        // R11 two-copy write with a simultaneous capture
        step(1, 8'h55, 3'b000, 0, 8'h00, 1, 3'b110, 8'h12, 3'b001, 8'h12, 0, 8'h12, "R11");

        // R10 leave test mode: copies converge
        step(0, 8'h00, 3'b000, 0, 8'h00, 1, 3'b001, 8'hE1, 3'b001, 8'h12, 0, 8'hE1, "R10");
        idle_step(8'h12, "R10");
        step(0, 8'h00, 3'b000, 0, 8'h00, 1, 3'b000, 8'h00, 3'b001, 8'h12, 0, 8'h12, "R10");

        // R5 / R6 slave double injection
        step(0, 8'h00, 3'b011, 1, 8'h0F, 0, 3'b000, 8'h00, 3'b000, 8'h1D, 1, 8'h00, "R5_R6");
        idle_step(8'h1D, "R6");
        step(0, 8'h00, 3'b110, 1, 8'h00, 0, 3'b000, 8'h00, 3'b000, 8'h1D, 0, 8'h00, "R5");

        // R5 master double injection with enable low, then capture
        step(0, 8'h00, 3'b101, 0, 8'hF0, 0, 3'b000, 8'h00, 3'b000, 8'h1D, 1, 8'h00, "R5");
        idle_step(8'h1D, "R3");
        step(1, 8'h5A, 3'b000, 0, 8'h00, 0, 3'b000, 8'h00, 3'b000, 8'h5A, 0, 8'h00, "R2");

        // R1 asynchronous clear between edges
        @(negedge clk);
        #0.5;
        arst_n = 1'b0;
        #0.5;
        check("R1", "q async", q, 8'h00);
        @(negedge clk);
        arst_n = 1'b1;
        step(1, 8'hC3, 3'b000, 0, 8'h00, 0, 3'b000, 8'h00, 3'b000, 8'hC3, 0, 8'h00, "R2");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule